// File: doc/BRIEF.md
# Accumulator Instruction Execution Core

This block is a small multi-cycle processor core. It fetches 16-bit opcodes from a single word-addressed memory and executes them one at a time. The state it holds is an accumulator, four general registers (A to D), a signed compare result and a program counter. Every opcode is one memory word. Immediate loads, stores and loads also read the next word as their operand: a literal value or a data address. Instruction fetches, operand fetches and data accesses all use the same request/valid handshake.

The opcode splits into two bytes. The upper byte picks the operation class and the lower byte picks the register. After reset the core starts at a start address set by a parameter. It runs until it meets a halt opcode or an opcode it does not recognise, and then it stays idle until the next reset. All architectural registers are brought out on ports so that a debug host or a testbench can observe them.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, the accumulator and registers A to D read zero, the compare code reads 2'b00, the program counter equals START_ADDR, and both halted and illegal are low. These values hold whatever state the core held before reset.
- R2: Opcode 0x1000 sets the accumulator to zero. Opcodes 0x1001, 0x1002, 0x1003 and 0x1004 set A, B, C and D to zero.
- R3: Opcodes 0x0001 to 0x0004 add A to D into the accumulator. The sum wraps modulo 2^DATA_W.
- R4: Opcodes 0x0101 to 0x0104 copy A to D into the accumulator. Opcodes 0x0201 to 0x0204 copy the accumulator into A to D.
- R5: Opcodes 0x0601 to 0x0604 write the next memory word into A to D. The program counter then advances past both words.
- R6: Opcodes 0x0301 to 0x0304 write A to D to memory. Opcodes 0x0401 to 0x0404 read memory into A to D. In both cases the address is the low ADDR_W bits of the word that follows the opcode. memWe is high only while memReq is high.
- R7: Opcodes 0x0501 to 0x0504 compare the accumulator with A to D as signed values. The compare code becomes 2'b01 when the accumulator is greater, 2'b00 when the two are equal and 2'b11 when it is less. The code never takes the value 2'b10.
- R8: Opcode 0x2000 raises halted with illegal low. A halted core issues no memory request, and its program counter and registers stay unchanged until reset.
- R9: Any other opcode raises both halted and illegal. This includes 0x0000, 0x0005, 0x0100, 0x0700, 0x1005, 0x2001 and 0x3000. The register effects of earlier instructions are kept, and no later instruction executes.
- R10: Bits DATA_W-1:16 of a fetched opcode word are ignored.
- R11: Count clock edges from the first edge after reset release, with a memory that answers every request one cycle later. An instruction without an operand takes 3 edges, an immediate load takes 5, and a load or store takes 7. Halted is visible after the last edge of the halt (or illegal) instruction.
- R12: Once memReq is high, it stays high with memAddr, memWe and memWdata unchanged until memValid is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Word address of the request |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid with memValid |
| memValid | input | 1 | Request completed this cycle |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an unknown opcode |
| dbgAcc | output | DATA_W | Accumulator |
| dbgRegA | output | DATA_W | Register A |
| dbgRegB | output | DATA_W | Register B |
| dbgRegC | output | DATA_W | Register C |
| dbgRegD | output | DATA_W | Register D |
| dbgCmp | output | 2 | Compare code |
| dbgPc | output | ADDR_W | Program counter |

## Verification
With a memory that answers one cycle after each request, an operand-free instruction retires on its third clock edge, an immediate load on its fifth, and a load or store on its seventh. Halted therefore rises after a number of edges that can be computed from the program. The bench sums these costs for each program and compares the sum with the edge on which it first sees halted, sampling on the falling edge. Register and memory results are read only after halted, when they can no longer change, and the reset values are read during reset, away from any clock edge.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W  = 16;
  localparam int NUM_GPR = 4;
  localparam int SEL_W = $clog2(NUM_GPR);

  typedef enum logic [3:0] {
    CL_ADD, CL_TOACC, CL_FROMACC, CL_STORE, CL_LOAD,
    CL_CMP, CL_MOVI, CL_CLRACC, CL_CLRREG, CL_HALT, CL_BAD
  } opClass_e;

  typedef enum logic [1:0] {ACC_ZERO, ACC_REG, ACC_SUM} accSrc_e;
  typedef enum logic [1:0] {RS_ZERO, RS_ACC, RS_MEM} regSrc_e;

  typedef struct packed {
    logic             latchOp;
    logic             latchOpnd;
    logic             pcInc;
    logic             accWr;
    accSrc_e          accSrc;
    logic             regWr;
    regSrc_e          regSrc;
    logic [SEL_W-1:0] regSel;
    logic             cmpWr;
    logic             addrFromOpnd;
  } ctrl_t;

  localparam logic [1:0] CMP_GT = 2'b01;
  localparam logic [1:0] CMP_EQ = 2'b00;
  localparam logic [1:0] CMP_LT = 2'b11;

endpackage

// File: rtl/acc_core_dec.sv
module acc_core_dec
  import acc_core_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  output opClass_e         opClass,
  output logic [SEL_W-1:0] regIdx,
  output logic             needsOpnd
);

  logic [7:0] hiByte;
  logic [7:0] loByte;
  logic [7:0] loMinus;
  logic       regOk;

  assign hiByte  = opcode[15:8];
  assign loByte  = opcode[7:0];
  assign loMinus = loByte - 8'd1;
  assign regIdx  = loMinus[SEL_W-1:0];
  assign regOk   = (loByte >= 8'd1) && (loByte <= 8'(NUM_GPR));

  always_comb begin
    opClass = CL_BAD;
    unique case (hiByte)
      8'h00: if (regOk) opClass = CL_ADD;
      8'h01: if (regOk) opClass = CL_TOACC;
      8'h02: if (regOk) opClass = CL_FROMACC;
      8'h03: if (regOk) opClass = CL_STORE;
      8'h04: if (regOk) opClass = CL_LOAD;
      8'h05: if (regOk) opClass = CL_CMP;
      8'h06: if (regOk) opClass = CL_MOVI;
      8'h10: begin
        if (loByte == 8'h00) opClass = CL_CLRACC;
        else if (regOk)      opClass = CL_CLRREG;
      end
      8'h20: if (loByte == 8'h00) opClass = CL_HALT;
      default: opClass = CL_BAD;
    endcase
  end

  assign needsOpnd = (opClass == CL_STORE) || (opClass == CL_LOAD) ||
                     (opClass == CL_MOVI);

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            memValid,
  input  logic [OP_W-1:0] curOp,
  output ctrl_t           ctl,
  output logic            memReq,
  output logic            memWe,
  output logic            halted,
  output logic            illegal
);

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_OPND, ST_MEMRD, ST_MEMWR, ST_HALT
  } state_e;

  state_e           stateQ, stateD;
  logic             illegalQ, illegalD;
  opClass_e         opClass;
  logic [SEL_W-1:0] regIdx;
  logic             needsOpnd;

  acc_core_dec u_dec (
    .opcode    (curOp),
    .opClass   (opClass),
    .regIdx    (regIdx),
    .needsOpnd (needsOpnd)
  );

  always_comb begin
    stateD   = stateQ;
    illegalD = illegalQ;
    memReq   = 1'b0;
    memWe    = 1'b0;
    ctl              = '0;
    ctl.accSrc       = ACC_ZERO;
    ctl.regSrc       = RS_ZERO;
    ctl.regSel       = regIdx;

    unique case (stateQ)
      ST_FETCH: begin
        memReq = 1'b1;
        if (memValid) begin
          ctl.latchOp = 1'b1;
          ctl.pcInc   = 1'b1;
          stateD      = ST_DECODE;
        end
      end
      ST_DECODE: begin
        stateD = ST_FETCH;
        if (needsOpnd) begin
          stateD = ST_OPND;
        end else begin
          unique case (opClass)
            CL_ADD: begin
              ctl.accWr  = 1'b1;
              ctl.accSrc = ACC_SUM;
            end
            CL_TOACC: begin
              ctl.accWr  = 1'b1;
              ctl.accSrc = ACC_REG;
            end
            CL_FROMACC: begin
              ctl.regWr  = 1'b1;
              ctl.regSrc = RS_ACC;
            end
            CL_CMP:     ctl.cmpWr = 1'b1;
            CL_CLRACC: begin
              ctl.accWr  = 1'b1;
              ctl.accSrc = ACC_ZERO;
            end
            CL_CLRREG: begin
              ctl.regWr  = 1'b1;
              ctl.regSrc = RS_ZERO;
            end
            CL_HALT:    stateD = ST_HALT;
            default: begin
              stateD   = ST_HALT;
              illegalD = 1'b1;
            end
          endcase
        end
      end
      ST_OPND: begin
        memReq = 1'b1;
        if (memValid) begin
          ctl.pcInc     = 1'b1;
          ctl.latchOpnd = 1'b1;
          if (opClass == CL_MOVI) begin
            ctl.regWr  = 1'b1;
            ctl.regSrc = RS_MEM;
            stateD     = ST_FETCH;
          end else if (opClass == CL_STORE) begin
            stateD = ST_MEMWR;
          end else begin
            stateD = ST_MEMRD;
          end
        end
      end
      ST_MEMWR: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        ctl.addrFromOpnd = 1'b1;
        if (memValid) stateD = ST_FETCH;
      end
      ST_MEMRD: begin
        memReq           = 1'b1;
        ctl.addrFromOpnd = 1'b1;
        if (memValid) begin
          ctl.regWr  = 1'b1;
          ctl.regSrc = RS_MEM;
          stateD     = ST_FETCH;
        end
      end
      ST_HALT: stateD = ST_HALT;
      default: stateD = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_FETCH;
      illegalQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      illegalQ <= illegalD;
    end
  end

  assign halted  = (stateQ == ST_HALT);
  assign illegal = illegalQ;

endmodule

// File: rtl/acc_core_dp.sv
module acc_core_dp
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [OP_W-1:0]   curOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] gprOut [NUM_GPR],
  output logic [1:0]        cmpOut,
  output logic [ADDR_W-1:0] pcOut
);

  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] gprQ [NUM_GPR];
  logic [1:0]        cmpQ;
  logic [ADDR_W-1:0] pcQ;
  logic [OP_W-1:0]   opQ;
  logic [DATA_W-1:0] opndQ;

  logic [DATA_W-1:0] selReg;
  logic [DATA_W-1:0] accNext;
  logic [DATA_W-1:0] regNext;
  logic [1:0]        cmpNext;

  assign selReg = gprQ[ctl.regSel];

  always_comb begin
    unique case (ctl.accSrc)
      ACC_REG: accNext = selReg;
      ACC_SUM: accNext = accQ + selReg;
      default: accNext = '0;
    endcase
  end

  always_comb begin
    unique case (ctl.regSrc)
      RS_ACC:  regNext = accQ;
      RS_MEM:  regNext = memRdata;
      default: regNext = '0;
    endcase
  end

  always_comb begin
    if ($signed(accQ) > $signed(selReg))       cmpNext = CMP_GT;
    else if ($signed(accQ) < $signed(selReg))  cmpNext = CMP_LT;
    else                                       cmpNext = CMP_EQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      cmpQ  <= CMP_EQ;
      pcQ   <= START_ADDR;
      opQ   <= '0;
      opndQ <= '0;
    end else begin
      if (ctl.accWr)     accQ  <= accNext;
      if (ctl.cmpWr)     cmpQ  <= cmpNext;
      if (ctl.pcInc)     pcQ   <= pcQ + ADDR_W'(1);
      if (ctl.latchOp)   opQ   <= memRdata[OP_W-1:0];
      if (ctl.latchOpnd) opndQ <= memRdata;
    end
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        gprQ[g] <= '0;
      end else if (ctl.regWr && (ctl.regSel == SEL_W'(g))) begin
        gprQ[g] <= regNext;
      end
    end
    assign gprOut[g] = gprQ[g];
  end

  assign curOp    = opQ;
  assign memAddr  = ctl.addrFromOpnd ? opndQ[ADDR_W-1:0] : pcQ;
  assign memWdata = selReg;
  assign accOut   = accQ;
  assign cmpOut   = cmpQ;
  assign pcOut    = pcQ;

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memValid,
  output logic              halted,
  output logic              illegal,
  output logic [DATA_W-1:0] dbgAcc,
  output logic [DATA_W-1:0] dbgRegA,
  output logic [DATA_W-1:0] dbgRegB,
  output logic [DATA_W-1:0] dbgRegC,
  output logic [DATA_W-1:0] dbgRegD,
  output logic [1:0]        dbgCmp,
  output logic [ADDR_W-1:0] dbgPc
);

  ctrl_t             ctl;
  logic [OP_W-1:0]   curOp;
  logic [DATA_W-1:0] gprOut [NUM_GPR];

  acc_core_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .memValid (memValid),
    .curOp    (curOp),
    .ctl      (ctl),
    .memReq   (memReq),
    .memWe    (memWe),
    .halted   (halted),
    .illegal  (illegal)
  );

  acc_core_dp #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memRdata (memRdata),
    .curOp    (curOp),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .accOut   (dbgAcc),
    .gprOut   (gprOut),
    .cmpOut   (dbgCmp),
    .pcOut    (dbgPc)
  );

  assign dbgRegA = gprOut[0];
  assign dbgRegB = gprOut[1];
  assign dbgRegC = gprOut[2];
  assign dbgRegD = gprOut[3];

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memValid,
  input logic              halted,
  input logic              illegal,
  input logic [DATA_W-1:0] dbgAcc,
  input logic [1:0]        dbgCmp,
  input logic [ADDR_W-1:0] dbgPc
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr) && $stable(memWe)
                               && $stable(memWdata)));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memReq);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(dbgPc) && $stable(dbgAcc)));

  // R9
  illegal_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> halted);

  // R7
  cmp_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgCmp != 2'b10);

  // R6
  we_with_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memValid (memValid),
  .halted   (halted),
  .illegal  (illegal),
  .dbgAcc   (dbgAcc),
  .dbgCmp   (dbgCmp),
  .dbgPc    (dbgPc)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] START = 8'h10;
  localparam int RUN_LIMIT = 400;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          memReq, memWe, memValid, halted, illegal;
  logic [AW-1:0] memAddr, dbgPc;
  logic [DW-1:0] memWdata, memRdata;
  logic [DW-1:0] dbgAcc, dbgRegA, dbgRegB, dbgRegC, dbgRegD;
  logic [1:0]    dbgCmp;

  logic [DW-1:0] mem [256];
  int checks = 0;
  int failures = 0;
  int wp;
  int haltCycle;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.DATA_W(DW), .ADDR_W(AW), .START_ADDR(START)) u_acc_core (
    .clk(clk), .rstN(rstN),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memValid(memValid),
    .halted(halted), .illegal(illegal),
    .dbgAcc(dbgAcc), .dbgRegA(dbgRegA), .dbgRegB(dbgRegB),
    .dbgRegC(dbgRegC), .dbgRegD(dbgRegD), .dbgCmp(dbgCmp), .dbgPc(dbgPc)
  );

  // memory answering each request one cycle later
  always @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
    end else if (memReq && !memValid) begin
      memValid <= 1'b1;
      memRdata <= mem[memAddr];
      if (memWe) mem[memAddr] <= memWdata;
    end else begin
      memValid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] regOf(input int i);
    case (i)
      0: return dbgRegA;
      1: return dbgRegB;
      2: return dbgRegC;
      default: return dbgRegD;
    endcase
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    wp = START;
  endtask

  task automatic put(input logic [DW-1:0] w);
    mem[wp] = w;
    wp++;
  endtask

  // reset, check reset state, run until halted; haltCycle = edge count
  task automatic runProg();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dbgAcc == '0 && dbgRegA == '0 && dbgRegB == '0 && dbgRegC == '0 &&
        dbgRegD == '0, "R1 regs", dbgAcc | dbgRegA | dbgRegB | dbgRegC | dbgRegD, '0);
    chk(dbgCmp == 2'b00 && dbgPc == START && !halted && !illegal, "R1 ctl",
        {dbgCmp, dbgPc, halted, illegal}, {2'b00, START, 2'b00});
    rstN = 1'b1;
    haltCycle = -1;
    for (int c = 1; c <= RUN_LIMIT; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (halted) begin
        haltCycle = c;
        break;
      end
    end
    if (haltCycle < 0) chk(1'b0, "watchdog run", '0, 32'd1);
  endtask

  logic [DW-1:0] cmpVals [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
  logic [15:0]   badOps [7] = '{16'h0000, 16'h0005, 16'h0100, 16'h0700,
                                16'h1005, 16'h2001, 16'h3000};

  initial begin : main
    logic [DW-1:0] v, w;
    logic [1:0]    expCmp;
    logic [AW-1:0] pcHold;
    bit            quiet;
    int            r2;

    // R3 R4 R5 R10 R11: movi, copy to acc, add with wrap, junk high bits
    for (int r = 0; r < 4; r++) begin
      clearMem();
      v = 32'h8000_0001 + DW'(r);
      put(32'h0000_0601 + DW'(r));
      put(v);
      put(32'hABCD_0101 + DW'(r));
      put(32'h5A5A_0001 + DW'(r));
      put(32'h0000_2000);
      runProg();
      chk(dbgAcc == 32'h2 + DW'(2*r), "R3 add wrap / R10", dbgAcc, 32'h2 + DW'(2*r));
      chk(regOf(r) == v, "R5 movi", regOf(r), v);
      chk(haltCycle == 14, "R11 cycles 5+3+3+3", DW'(haltCycle), 32'd14);
      chk(dbgPc == START + 8'd5, "R5 pc advance", DW'(dbgPc), DW'(START + 8'd5));
      chk(!illegal, "R8 halt legal", DW'(illegal), 32'd0);
    end

    // R2 R4: copy out of acc, clear register and acc
    for (int r = 0; r < 4; r++) begin
      clearMem();
      r2 = (r + 1) % 4;
      v = 32'h1234_0000 + DW'(r);
      put(32'h0601 + DW'(r)); put(v);
      put(32'h0101 + DW'(r));
      put(32'h1001 + DW'(r));
      put(32'h0201 + DW'(r2));
      put(32'h1000);
      put(32'h2000);
      runProg();
      chk(regOf(r2) == v, "R4 acc to reg", regOf(r2), v);
      chk(regOf(r) == '0, "R2 clear reg", regOf(r), '0);
      chk(dbgAcc == '0, "R2 clear acc", dbgAcc, '0);
    end

    // R6 R11: load then store via operand address
    for (int r = 0; r < 4; r++) begin
      clearMem();
      w = 32'hC0DE_0000 + DW'(r);
      mem[8'hC0 + r] = w;
      put(32'h0401 + DW'(r)); put(32'h0000_00C0 + DW'(r));
      put(32'h0301 + DW'(r)); put(32'hFFFF_FFD0 + DW'(r));
      put(32'h2000);
      runProg();
      chk(regOf(r) == w, "R6 load", regOf(r), w);
      chk(mem[8'hD0 + r] == w, "R6 store low addr bits", mem[8'hD0 + r], w);
      chk(haltCycle == 17, "R11 cycles 7+7+3", DW'(haltCycle), 32'd17);
    end

    // R7: signed compare sweep
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        int r;
        r = (i + j) % 4;
        clearMem();
        put(32'h0601); put(cmpVals[i]);
        put(32'h0101);
        put(32'h0601 + DW'(r)); put(cmpVals[j]);
        put(32'h0501 + DW'(r));
        put(32'h2000);
        runProg();
        if ($signed(cmpVals[i]) > $signed(cmpVals[j]))      expCmp = 2'b01;
        else if ($signed(cmpVals[i]) < $signed(cmpVals[j])) expCmp = 2'b11;
        else                                                 expCmp = 2'b00;
        chk(dbgCmp == expCmp, "R7 compare", DW'(dbgCmp), DW'(expCmp));
      end
    end

    // R8 R9 R11: illegal opcodes stop the core and keep earlier effects
    for (int k = 0; k < 7; k++) begin
      clearMem();
      put(32'h0601); put(32'd5);
      put(DW'(badOps[k]));
      put(32'h0602); put(32'd7);
      put(32'h2000);
      runProg();
      chk(illegal && halted, "R9 illegal flag", DW'({halted, illegal}), 32'd3);
      chk(dbgRegA == 32'd5 && dbgRegB == '0, "R9 effects", dbgRegB, '0);
      chk(haltCycle == 8, "R11 cycles 5+3", DW'(haltCycle), 32'd8);
      pcHold = dbgPc;
      quiet = 1'b1;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (memReq || !halted) quiet = 1'b0;
      end
      chk(quiet && dbgPc == pcHold && dbgRegB == '0, "R8 stays idle",
          DW'(dbgPc), DW'(pcHold));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule